// File: doc/BRIEF.md
# AES Single-Round Cipher Unit

This block performs one AES round transformation on a 128-bit state for each request. An 8-bit opcode selects the operation. Four operations run a forward or inverse round, in its full form or its final-round form. The fifth applies only the inverse column mix to a round key, which turns an encryption round key into one usable in the equivalent inverse cipher. A request carries the current state, a second 128-bit operand and the opcode. The second operand is the round key for the round operations and the source word for the key-conversion operation.

Requests enter through a valid/ready handshake. The unit registers the result and presents it one cycle after it accepts the request. The state is handled column-major. Byte `i` of a 128-bit word occupies bits `[8i+7:8i]`, and column `j` holds bytes `4j` to `4j+3`, with the row number running from 0 to 3 inside the column. Key scheduling and operand fetch are left to the surrounding logic.

Top module: `aes_round_unit`

## Requirements
- R1: After reset, `out_valid`, `out_write` and `out_illegal` are low and `in_ready` is high.
- R2: Opcode 0xDC returns MixColumns(SubBytes(ShiftRows(state))) XOR key. ShiftRows moves the byte at column c, row r to column (c-r) mod 4, row r. MixColumns computes output row k of each column as 02·a[k] ^ 03·a[k+1] ^ a[k+2] ^ a[k+3], with indices taken mod 4, in GF(2^8) under the polynomial 0x11B.
- R3: Opcode 0xDD returns SubBytes(ShiftRows(state)) XOR key, with no column mix. With an all-zero state and an all-zero key, every result byte is 0x63.
- R4: Opcode 0xDE returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. InvShiftRows moves the byte at column c, row r to column (c+r) mod 4, row r. InvMixColumns uses the coefficients 0E, 0B, 0D, 09, rotated per row in the same way as R2.
- R5: Opcode 0xDF returns InvSubBytes(InvShiftRows(state)) XOR key, with no column mix.
- R6: Opcode 0xDB returns InvMixColumns(key). The state operand has no effect on the result, and no XOR is applied.
- R7: Any other opcode produces a response with `out_illegal` high, `out_write` low and `out_data` zero. Supported opcodes produce `out_write` high and `out_illegal` low. Both flags are low whenever `out_valid` is low.
- R8: A request accepted at a clock edge presents `out_valid` with its result after that same edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_write` and `out_illegal` hold their values. When `out_ready` rises, a pending response and a new request are exchanged at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_opcode | input | 8 | Operation selector |
| in_state | input | 128 | State operand |
| in_key | input | 128 | Round key or source word |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_data | output | 128 | Result |
| out_write | output | 1 | Result is to be written to the destination |
| out_illegal | output | 1 | Opcode was not supported |

## Verification
Each of the five operations is run with 256 state and key patterns. Across those patterns every byte position takes many different values. A wrong S-box entry, a wrong byte shuffle or a wrong mixing coefficient therefore shows up at a specific byte. An all-zero vector pins down the constant of the forward S-box. The key-conversion opcode is applied twice with different states and the same key, which shows whether it ignores the state. All 256 opcodes are swept, so decoding errors show up both on the five legal values and on their neighbours. A stalled response with a second request queued behind it separates correct holding from overwriting.

// File: rtl/aes_round_unit.sv
module aes_round_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   in_opcode,
  input  logic [127:0] in_state,
  input  logic [127:0] in_key,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic         out_write,
  output logic         out_illegal
);
  localparam logic [7:0] OP_ENC   = 8'hDC;
  localparam logic [7:0] OP_ENCL  = 8'hDD;
  localparam logic [7:0] OP_DEC   = 8'hDE;
  localparam logic [7:0] OP_DECL  = 8'hDF;
  localparam logic [7:0] OP_IMIX  = 8'hDB;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, base;
    r = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gm(r, base);
      base = gm(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] y, s;
    y = ginv(x);
    for (int i = 0; i < 8; i++)
      s[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  function automatic logic [7:0] isb(input logic [7:0] x);
    logic [7:0] z;
    for (int i = 0; i < 8; i++)
      z[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
    return ginv(z ^ 8'h05);
  endfunction

  function automatic logic [127:0] mixcols(input logic [127:0] x, input logic inv);
    logic [127:0] r;
    logic [7:0] a [4];
    logic [7:0] c [4];
    if (inv) c = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     c = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < 4; k++) a[k] = x[32*j+8*k +: 8];
      for (int k = 0; k < 4; k++)
        r[32*j+8*k +: 8] = gm(c[0], a[k]) ^ gm(c[1], a[(k+1)%4])
                         ^ gm(c[2], a[(k+2)%4]) ^ gm(c[3], a[(k+3)%4]);
    end
    return r;
  endfunction

  logic [127:0] sub_f, sub_i, mix_f, mix_i, imix;
  logic [127:0] nxt_data;
  logic         nxt_ok;

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sub_f[32*c+8*r +: 8] = sb(in_state[32*((c+r)%4)+8*r +: 8]);
      assign sub_i[32*c+8*r +: 8] = isb(in_state[32*((c+4-r)%4)+8*r +: 8]);
    end
  end

  assign mix_f = mixcols(sub_f, 1'b0);
  assign mix_i = mixcols(sub_i, 1'b1);
  assign imix  = mixcols(in_key, 1'b1);

  always_comb begin
    nxt_ok = 1'b1;
    case (in_opcode)
      OP_ENC:  nxt_data = mix_f ^ in_key;
      OP_ENCL: nxt_data = sub_f ^ in_key;
      OP_DEC:  nxt_data = mix_i ^ in_key;
      OP_DECL: nxt_data = sub_i ^ in_key;
      OP_IMIX: nxt_data = imix;
      default: begin
        nxt_data = '0;
        nxt_ok   = 1'b0;
      end
    endcase
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_write   <= 1'b0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_data    <= nxt_data;
      out_write   <= nxt_ok;
      out_illegal <= !nxt_ok;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_write   <= 1'b0;
      out_illegal <= 1'b0;
    end
  end

  p_flags_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_write && !out_illegal);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_write ^ out_illegal));
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_write) && $stable(out_illegal));
  p_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == OP_IMIX |=> out_write);
endmodule

// File: tb/aes_round_unit_test.sv
module aes_round_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_opcode = 8'h00;
  logic [127:0] in_state = '0, in_key = '0;
  logic in_ready, out_valid, out_write, out_illegal;
  logic [127:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  aes_round_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_state(in_state), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_write(out_write), .out_illegal(out_illegal));

  logic [7:0] ex [256];
  logic [7:0] lg [256];
  logic [7:0] sbt [256];
  logic [7:0] isbt [256];
  localparam int PF[16] = '{11,6,1,12,7,2,13,8,3,14,9,4,15,10,5,0};
  localparam int PI[16] = '{3,6,9,12,15,2,5,8,11,14,1,4,7,10,13,0};

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] gml(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return ex[(int'(lg[a]) + int'(lg[b])) % 255];
  endfunction

  function automatic logic [127:0] model(input logic [7:0] op, input logic [127:0] s,
                                         input logic [127:0] k);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [7:0] c0, c1, c2, c3;
    logic [127:0] r;
    logic inv, mix, kx;
    inv = (op == 8'hDE || op == 8'hDF || op == 8'hDB);
    mix = (op == 8'hDC || op == 8'hDE || op == 8'hDB);
    kx  = (op != 8'hDB);
    if (!(op == 8'hDC || op == 8'hDD || op == 8'hDE || op == 8'hDF || op == 8'hDB))
      return '0;
    for (int i = 0; i < 16; i++) a[i] = (op == 8'hDB) ? k[8*i +: 8] : s[8*i +: 8];
    if (op != 8'hDB)
      for (int i = 0; i < 16; i++) begin
        b[15-i] = inv ? isbt[a[PI[i]]] : sbt[a[PF[i]]];
      end
    else
      for (int i = 0; i < 16; i++) b[i] = a[i];
    if (mix) begin
      if (inv) begin c0 = 8'h0e; c1 = 8'h0b; c2 = 8'h0d; c3 = 8'h09; end
      else     begin c0 = 8'h02; c1 = 8'h03; c2 = 8'h01; c3 = 8'h01; end
      for (int j = 0; j < 4; j++)
        for (int q = 0; q < 4; q++)
          a[4*j+q] = gml(c0, b[4*j+q]) ^ gml(c1, b[4*j+(q+1)%4])
                   ^ gml(c2, b[4*j+(q+2)%4]) ^ gml(c3, b[4*j+(q+3)%4]);
      for (int i = 0; i < 16; i++) b[i] = a[i];
    end
    for (int i = 0; i < 16; i++) r[8*i +: 8] = b[i];
    return kx ? (r ^ k) : r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [127:0] s, input logic [127:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_state = s; in_key = k; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] pat(input int v, input int salt);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'((v * 7 + i * 29 + v * i * salt + salt * 13) & 255);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] e, r1, hold;
    logic [7:0] ops [5];
    ops = '{8'hDC, 8'hDD, 8'hDE, 8'hDF, 8'hDB};
    ex[0] = 8'h01;
    for (int i = 1; i < 256; i++)
      ex[i] = ex[i-1] ^ {ex[i-1][6:0], 1'b0} ^ (ex[i-1][7] ? 8'h1b : 8'h00);
    lg[0] = 8'h00;
    for (int i = 0; i < 255; i++) lg[ex[i]] = 8'(i);
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v;
      v = (x == 0) ? 8'h00 : ex[(255 - int'(lg[x])) % 255];
      sbt[x] = v ^ rl(v, 1) ^ rl(v, 2) ^ rl(v, 3) ^ rl(v, 4) ^ 8'h63;
    end
    for (int y = 0; y < 256; y++) isbt[sbt[y]] = 8'(y);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_write && !out_illegal && in_ready, "R1 reset",
        {124'd0, out_valid, out_write, out_illegal, in_ready}, 128'h1);

    issue(8'hDD, '0, '0);
    chk(out_data == {16{8'h63}} && out_valid, "R3 zero vector", out_data, {16{8'h63}});

    for (int v = 0; v < 256; v++)
      for (int o = 0; o < 5; o++) begin
        e = model(ops[o], pat(v, 3), pat(v, 5));
        issue(ops[o], pat(v, 3), pat(v, 5));
        case (o)
          0: chk(out_valid && out_write && !out_illegal && out_data == e, "R2 enc", out_data, e);
          1: chk(out_valid && out_write && !out_illegal && out_data == e, "R3 enclast", out_data, e);
          2: chk(out_valid && out_write && !out_illegal && out_data == e, "R4 dec", out_data, e);
          3: chk(out_valid && out_write && !out_illegal && out_data == e, "R5 declast", out_data, e);
          default: chk(out_valid && out_write && !out_illegal && out_data == e, "R6 imix", out_data, e);
        endcase
      end

    issue(8'hDB, pat(1, 1), pat(9, 2));
    r1 = out_data;
    issue(8'hDB, pat(200, 7), pat(9, 2));
    chk(out_data == r1, "R6 state ignored", out_data, r1);

    for (int op = 0; op < 256; op++) begin
      if (op == 'hDB || op == 'hDC || op == 'hDD || op == 'hDE || op == 'hDF) continue;
      issue(8'(op), pat(op, 1), pat(op, 2));
      chk(out_valid && out_illegal && !out_write && out_data == '0, "R7 illegal",
          {out_data[124:0], out_valid, out_illegal, out_write}, 128'h6);
    end
    @(negedge clk);
    chk(!out_valid && !out_write && !out_illegal, "R7 flags cleared",
        {125'd0, out_valid, out_write, out_illegal}, 128'h0);

    @(negedge clk);
    in_valid = 1'b1; in_opcode = 8'hDC; in_state = pat(4, 4); in_key = pat(5, 5);
    out_ready = 1'b0;
    chk(!out_valid, "R8 before accept", {127'd0, out_valid}, 128'h0);
    @(posedge clk);
    @(negedge clk);
    hold = model(8'hDC, pat(4, 4), pat(5, 5));
    chk(out_valid && out_data == hold, "R8 one cycle", out_data, hold);
    in_opcode = 8'hDE; in_state = pat(6, 6); in_key = pat(7, 7);
    for (int i = 0; i < 3; i++) begin
      chk(!in_ready, "R9 stalled ready", {127'd0, in_ready}, 128'h0);
      @(negedge clk);
      chk(out_valid && out_data == hold, "R9 hold", out_data, hold);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e = model(8'hDE, pat(6, 6), pat(7, 7));
    chk(out_valid && out_data == e, "R9 swap", out_data, e);
    @(negedge clk);
    chk(!out_valid, "R9 drained", {127'd0, out_valid}, 128'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule